// File: doc/BRIEF.md
# Compare Buffer Auto-Lock Controller

This block keeps the compare values of a timer's three compare channels double-buffered. Software writes go into a per-channel buffer, and each write raises that channel's valid flag. The active compare value that the waveform logic uses only changes when the timer signals an update event and the transfer lock is open. On a transfer, every channel whose buffer holds fresh data is copied into its active register, and its valid flag drops.

The lock can be driven by software with set and clear strobes. With the auto-lock mode switched on, hardware takes the lock over. The lock closes as auto-lock is switched on. It opens once every enabled channel holds fresh data. It then stays open until the next update event, and that event performs the transfer and closes the lock again. A new set of compare values therefore reaches all enabled channels together, never one channel at a time. The counter that produces update events lives outside this block.

Top module: `cmp_buf_lock_ctrl`

## Requirements
- R1: In the first cycle that `auto_lock_i` is high after a cycle in which it was low, the lock is set (`lock_o` reads 1 after that clock edge).
- R2: While auto-lock stays on and the lock is set, the lock clears at the first edge where every channel with its `ch_en_i` bit at 1 has its valid flag at 1. Channels with the enable bit at 0 are ignored, and with no channel enabled the condition counts as met.
- R3: While auto-lock stays on and the lock is clear, the lock stays clear until an update event. The update event transfers the buffers and sets the lock at the same edge.
- R4: An update event that arrives while the lock is set transfers nothing, and every active compare value stays unchanged.
- R5: With auto-lock off, hardware leaves the lock alone. A `lock_set_i` pulse sets it and a `lock_clr_i` pulse clears it. When both are high, set wins.
- R6: With auto-lock on, `lock_set_i` and `lock_clr_i` have no effect on the lock.
- R7: A buffer write sets that channel's valid flag at the next edge and does not change its active compare value.
- R8: A transfer (update event with the lock clear) copies each channel whose valid flag is 1 into its active value and clears that flag. A channel whose flag is 0 keeps its active value.
- R9: When a buffer write and a transfer hit the same channel in the same cycle, the active value takes the old buffer content, the new data stays in the buffer, and the valid flag stays 1.
- R10: Reset clears all buffers, active compare values, valid flags and the lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| buf_we_i | input | N_CH | Buffer write strobe per channel |
| buf_wdata_i | input | N_CH*CMP_W | Write data, channel n in bits [n*CMP_W +: CMP_W] |
| ch_en_i | input | N_CH | Channel enable, selects channels for the all-valid check |
| auto_lock_i | input | 1 | Auto-lock mode on |
| lock_set_i | input | 1 | Software lock set strobe |
| lock_clr_i | input | 1 | Software lock clear strobe |
| update_i | input | 1 | Update event pulse from the timer |
| cmp_o | output | N_CH*CMP_W | Active compare values, channel n in bits [n*CMP_W +: CMP_W] |
| buf_valid_o | output | N_CH | Buffer valid flags |
| lock_o | output | 1 | Transfer lock |

## Verification
Two functions can fall in the same cycle: a software buffer write and an update-driven transfer on the same channel. The bench lets the auto-lock open with known buffer contents. It then drives the update pulse and a new write to channel 0 in one cycle. The result passes if the active value shows the old buffer content, the valid flag stays set, and the lock closes again. A second transfer, released once the other enabled channel is rewritten, must then bring the new data out, which shows that the data was kept in the buffer.

// File: rtl/cmp_buf_pkg.sv
package cmp_buf_pkg;
  localparam int unsigned DEF_N_CH  = 3;
  localparam int unsigned DEF_CMP_W = 16;

  typedef enum logic [1:0] {
    LOCK_HOLD = 2'd0,
    LOCK_SET  = 2'd1,
    LOCK_CLR  = 2'd2
  } lock_act_e;
endpackage

// File: rtl/cmp_buf_slot.sv
module cmp_buf_slot #(
  parameter int unsigned CMP_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CMP_W-1:0] wdata_i,
  input  logic             xfer_i,
  output logic [CMP_W-1:0] cmp_o,
  output logic             valid_o
);
  logic [CMP_W-1:0] buf_q, cmp_q;
  logic             valid_q;
  logic             copy;

  assign copy = xfer_i & valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q   <= '0;
      cmp_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      // copy uses the old buffer content; a write in the same cycle stays pending
      if (copy)  cmp_q <= buf_q;
      if (we_i)  buf_q <= wdata_i;
      if (we_i)       valid_q <= 1'b1;
      else if (copy)  valid_q <= 1'b0;
    end
  end

  assign cmp_o   = cmp_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/cmp_lock_ctrl.sv
module cmp_lock_ctrl
  import cmp_buf_pkg::*;
#(
  parameter int unsigned N_CH = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            auto_lock_i,
  input  logic            lock_set_i,
  input  logic            lock_clr_i,
  input  logic            update_i,
  input  logic [N_CH-1:0] ch_en_i,
  input  logic [N_CH-1:0] valid_i,
  output logic            lock_o,
  output logic            xfer_o
);
  logic      lock_q, auto_q;
  logic      all_valid;
  lock_act_e act;

  // disabled channels count as ready
  assign all_valid = &(valid_i | ~ch_en_i);
  assign xfer_o    = update_i & ~lock_q;

  always_comb begin
    act = LOCK_HOLD;
    if (auto_lock_i) begin
      if (!auto_q)                  act = LOCK_SET;
      else if (!lock_q && update_i) act = LOCK_SET;
      else if (lock_q && all_valid) act = LOCK_CLR;
    end else begin
      if (lock_set_i)      act = LOCK_SET;
      else if (lock_clr_i) act = LOCK_CLR;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q <= 1'b0;
      auto_q <= 1'b0;
    end else begin
      auto_q <= auto_lock_i;
      unique case (act)
        LOCK_SET: lock_q <= 1'b1;
        LOCK_CLR: lock_q <= 1'b0;
        default:  lock_q <= lock_q;
      endcase
    end
  end

  assign lock_o = lock_q;
endmodule

// File: rtl/cmp_buf_lock_ctrl.sv
module cmp_buf_lock_ctrl
  import cmp_buf_pkg::*;
#(
  parameter int unsigned N_CH  = DEF_N_CH,
  parameter int unsigned CMP_W = DEF_CMP_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [N_CH-1:0]       buf_we_i,
  input  logic [N_CH*CMP_W-1:0] buf_wdata_i,
  input  logic [N_CH-1:0]       ch_en_i,
  input  logic                  auto_lock_i,
  input  logic                  lock_set_i,
  input  logic                  lock_clr_i,
  input  logic                  update_i,
  output logic [N_CH*CMP_W-1:0] cmp_o,
  output logic [N_CH-1:0]       buf_valid_o,
  output logic                  lock_o
);
  logic xfer;

  cmp_lock_ctrl #(.N_CH(N_CH)) u_lock (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .auto_lock_i (auto_lock_i),
    .lock_set_i  (lock_set_i),
    .lock_clr_i  (lock_clr_i),
    .update_i    (update_i),
    .ch_en_i     (ch_en_i),
    .valid_i     (buf_valid_o),
    .lock_o      (lock_o),
    .xfer_o      (xfer)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    cmp_buf_slot #(.CMP_W(CMP_W)) u_slot (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (buf_we_i[g]),
      .wdata_i (buf_wdata_i[g*CMP_W +: CMP_W]),
      .xfer_i  (xfer),
      .cmp_o   (cmp_o[g*CMP_W +: CMP_W]),
      .valid_o (buf_valid_o[g])
    );
  end
endmodule

// File: rtl/cmp_buf_lock_checker.sv
module cmp_buf_lock_checker #(
  parameter int unsigned N_CH  = 3,
  parameter int unsigned CMP_W = 16
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [N_CH-1:0]       buf_we_i,
  input logic [N_CH-1:0]       ch_en_i,
  input logic                  auto_lock_i,
  input logic                  lock_set_i,
  input logic                  lock_clr_i,
  input logic                  update_i,
  input logic [N_CH*CMP_W-1:0] cmp_o,
  input logic [N_CH-1:0]       buf_valid_o,
  input logic                  lock_o
);
  logic auto_prev;
  logic all_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) auto_prev <= 1'b0;
    else         auto_prev <= auto_lock_i;
  end

  assign all_ok = &(buf_valid_o | ~ch_en_i);

  AST_AUTO_RISE_LOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_lock_i && !auto_prev) |=> lock_o); // R1

  AST_ALL_VALID_UNLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_lock_i && auto_prev && lock_o && all_ok) |=> !lock_o); // R2

  AST_NOT_READY_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_lock_i && auto_prev && lock_o && !all_ok) |=> lock_o); // R2

  AST_OPEN_UNTIL_UPDATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_lock_i && auto_prev && !lock_o && !update_i) |=> !lock_o); // R3

  AST_UPDATE_RELOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_lock_i && !lock_o && update_i) |=> lock_o); // R3

  AST_LOCKED_NO_XFER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_o |=> $stable(cmp_o)); // R4

  AST_MANUAL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!auto_lock_i && !lock_set_i && !lock_clr_i) |=> $stable(lock_o)); // R5

  AST_MANUAL_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!auto_lock_i && lock_set_i) |=> lock_o); // R5

  AST_WRITE_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|buf_we_i) |=> ((buf_valid_o & $past(buf_we_i)) == $past(buf_we_i))); // R7

  AST_NO_UPDATE_NO_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !update_i |=> $stable(cmp_o)); // R8
endmodule

bind cmp_buf_lock_ctrl cmp_buf_lock_checker #(.N_CH(N_CH), .CMP_W(CMP_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .buf_we_i    (buf_we_i),
  .ch_en_i     (ch_en_i),
  .auto_lock_i (auto_lock_i),
  .lock_set_i  (lock_set_i),
  .lock_clr_i  (lock_clr_i),
  .update_i    (update_i),
  .cmp_o       (cmp_o),
  .buf_valid_o (buf_valid_o),
  .lock_o      (lock_o)
);

// File: tb/cmp_buf_lock_ctrl_bench.sv
module cmp_buf_lock_ctrl_bench;
  localparam int N_CH     = 3;
  localparam int CMP_W    = 16;
  localparam int CLK_HALF = 5;

  logic                  clk_i = 1'b0;
  logic                  rst_ni = 1'b0;
  logic [N_CH-1:0]       buf_we_i = '0;
  logic [N_CH*CMP_W-1:0] buf_wdata_i = '0;
  logic [N_CH-1:0]       ch_en_i = '0;
  logic                  auto_lock_i = 1'b0;
  logic                  lock_set_i = 1'b0;
  logic                  lock_clr_i = 1'b0;
  logic                  update_i = 1'b0;
  logic [N_CH*CMP_W-1:0] cmp_o;
  logic [N_CH-1:0]       buf_valid_o;
  logic                  lock_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #CLK_HALF clk_i = ~clk_i;

  cmp_buf_lock_ctrl #(.N_CH(N_CH), .CMP_W(CMP_W)) u_cmp_buf_lock_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .buf_we_i    (buf_we_i),
    .buf_wdata_i (buf_wdata_i),
    .ch_en_i     (ch_en_i),
    .auto_lock_i (auto_lock_i),
    .lock_set_i  (lock_set_i),
    .lock_clr_i  (lock_clr_i),
    .update_i    (update_i),
    .cmp_o       (cmp_o),
    .buf_valid_o (buf_valid_o),
    .lock_o      (lock_o)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // one clock edge, then settle; inputs change and outputs are sampled here
  task automatic step();
    @(posedge clk_i);
    #1;
  endtask

  function automatic logic [CMP_W-1:0] cmp_of(int ch);
    return cmp_o[ch*CMP_W +: CMP_W];
  endfunction

  task automatic wr(int ch, logic [CMP_W-1:0] d);
    buf_we_i[ch] = 1'b1;
    buf_wdata_i[ch*CMP_W +: CMP_W] = d;
  endtask

  task automatic idle();
    buf_we_i = '0; update_i = 1'b0; lock_set_i = 1'b0; lock_clr_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R10 cmp", 64'(cmp_o), 64'h0);
    chk("R10 valid", 64'(buf_valid_o), 64'h0);
    chk("R10 lock", 64'(lock_o), 64'h0);
  endtask

  task automatic t_manual();
    auto_lock_i = 1'b0;
    lock_set_i = 1'b1; step(); idle();
    chk("R5 sw set", 64'(lock_o), 64'h1);
    wr(0, 16'h1111); step(); idle();
    chk("R7 valid set", 64'(buf_valid_o), 64'h1);
    chk("R7 cmp unchanged", 64'(cmp_of(0)), 64'h0);
    update_i = 1'b1; step(); idle();
    chk("R4 locked update", 64'(cmp_of(0)), 64'h0);
    chk("R4 valid kept", 64'(buf_valid_o), 64'h1);
    step();
    chk("R5 lock held", 64'(lock_o), 64'h1);
    lock_clr_i = 1'b1; step(); idle();
    chk("R5 sw clear", 64'(lock_o), 64'h0);
    update_i = 1'b1; step(); idle();
    chk("R8 ch0 copied", 64'(cmp_of(0)), 64'h1111);
    chk("R8 ch1 kept", 64'(cmp_of(1)), 64'h0);
    chk("R8 flag cleared", 64'(buf_valid_o), 64'h0);
    chk("R5 no hw relock", 64'(lock_o), 64'h0);
    lock_set_i = 1'b1; lock_clr_i = 1'b1; step(); idle();
    chk("R5 set wins", 64'(lock_o), 64'h1);
    lock_clr_i = 1'b1; step(); idle();
  endtask

  task automatic t_auto();
    ch_en_i = 3'b011;
    auto_lock_i = 1'b1; step();
    chk("R1 lock on enable", 64'(lock_o), 64'h1);
    wr(0, 16'h2222); wr(2, 16'h7777); step(); idle();
    step();
    chk("R2 still locked", 64'(lock_o), 64'h1);
    update_i = 1'b1; step(); idle();
    chk("R4 blocked", 64'(cmp_of(0)), 64'h1111);
    wr(1, 16'h3333); step(); idle();
    chk("R2 locked at valid edge", 64'(lock_o), 64'h1);
    step();
    chk("R2 unlocked", 64'(lock_o), 64'h0);
    lock_set_i = 1'b1; step(); idle();
    chk("R6 sw set ignored", 64'(lock_o), 64'h0);
    step(); step();
    chk("R3 stays clear", 64'(lock_o), 64'h0);
    update_i = 1'b1; step(); idle();
    chk("R3 ch0", 64'(cmp_of(0)), 64'h2222);
    chk("R3 ch1", 64'(cmp_of(1)), 64'h3333);
    chk("R8 disabled valid ch2", 64'(cmp_of(2)), 64'h7777);
    chk("R3 relocked", 64'(lock_o), 64'h1);
    chk("R8 flags cleared", 64'(buf_valid_o), 64'h0);
    lock_clr_i = 1'b1; step(); idle();
    chk("R6 sw clear ignored", 64'(lock_o), 64'h1);
  endtask

  task automatic t_collide();
    wr(0, 16'hAAAA); wr(1, 16'hBBBB); step(); idle();
    step();
    chk("R2 open", 64'(lock_o), 64'h0);
    update_i = 1'b1; wr(0, 16'hCCCC); step(); idle();
    chk("R9 old value", 64'(cmp_of(0)), 64'hAAAA);
    chk("R9 valid kept", 64'(buf_valid_o), 64'h1);
    chk("R9 relock", 64'(lock_o), 64'h1);
    wr(1, 16'hDDDD); step(); idle();
    step();
    update_i = 1'b1; step(); idle();
    chk("R9 new value", 64'(cmp_of(0)), 64'hCCCC);
    chk("R9 ch1", 64'(cmp_of(1)), 64'hDDDD);
  endtask

  task automatic t_none_enabled();
    chk("R2 locked pre", 64'(lock_o), 64'h1);
    ch_en_i = '0; step();
    chk("R2 none enabled", 64'(lock_o), 64'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    t_reset();
    rst_ni = 1'b1;
    step();
    t_reset();
    t_manual();
    t_auto();
    t_collide();
    t_none_enabled();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule